// File: doc/BRIEF.md
# Programmable Interval Timer Channel

A single down-counting channel of a classic programmable interval timer. The counter advances once for each clock cycle in which the count-enable `tick` is high. A `gate` input either holds the count or restarts it, depending on the selected mode. Software reaches the channel through a byte-wide port. When `sel_ctrl` is high, a write carries a control byte. When `sel_ctrl` is low, a write carries one byte of the initial count. Reads return a byte of the current count, or of a frozen snapshot of it.

Six counting modes shape the `out` waveform:
- terminal flag (mode 0)
- gate-triggered one-shot (mode 1)
- rate pulse (mode 2)
- square wave (mode 3)
- software-started strobe (mode 4)
- gate-started strobe (mode 5)

The counter counts in binary or in four-digit BCD. The byte sequencing on the port follows the access pattern named in the control byte. The block is meant to sit behind an address decoder that picks one of several such channels.

Top module: `pit_channel`

## Requirements
- R1: After reset, `out` is 1, the count is 0 and the channel is in mode 0, binary, low-byte access. Control byte layout: bit 0 selects BCD; bits 3:1 select the mode, with 6 and 7 acting as 2 and 3; bits 5:4 select access, where 00 is a latch command, 01 is low byte only, 10 is high byte only and 11 is low then high.
- R2: In low-only access a written byte loads the value {00,byte}. In high-only access it loads {byte,00}. In word access the first write supplies the low byte and the second write supplies the high byte and completes the load. Reads follow the same pattern: word reads alternate low then high, starting from low after each control write.
- R3: An initial count of 0 acts as 65536 ticks in binary or 10000 ticks in BCD.
- R4: In binary the count wraps from 0000 to FFFF. In BCD each of the four digits borrows from its neighbour, and 0000 wraps to 9999. Modes 0, 1, 4 and 5 keep counting through the wrap.
- R5: Mode 0 drives `out` low on a control write or a count load. `out` goes high on the tick that takes the count to 0 and stays high until the next write.
- R6: Mode 1 starts on a gate rising edge: it reloads the count and drives `out` low. `out` goes high again at terminal count. A new rising edge retriggers the mode. Ticks before the first trigger have no effect.
- R7: Mode 2 with count N (N ≥ 2) drives `out` low for one tick interval after every N ticks, and reloads N at that tick. There is no pulse at load.
- R8: Mode 3 with count N keeps `out` high for the first (N+1)/2 ticks of each N-tick period and low for the rest.
- R9: Mode 4 strobes `out` low for one tick interval when the count N has elapsed after a load. It then stays high, including across later wraps.
- R10: Mode 5 behaves like mode 4, but counting starts on a gate rising edge. Ticks before that edge have no effect.
- R11: In modes 0, 2, 3 and 4 a low gate holds the count. In modes 0 and 4 a gate rising edge does not reload the count. In modes 2 and 3 a gate rising edge reloads the initial count.
- R12: A latch command freezes the current count for reads until it has been fully read, which is one read in low-only or high-only access and two reads in word access. A second latch command before that is ignored. Later reads show the live count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-enable; one count step per high cycle |
| gate | input | 1 | Gate level / trigger input |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; advances the read byte pointer |
| sel_ctrl | input | 1 | 1: write is a control byte, 0: write is a count byte |
| wdata | input | BYTE_W | Write data |
| rdata | output | BYTE_W | Read data for the current byte (combinational) |
| out | output | 1 | Channel output waveform |

## Verification
Three kinds of result have different timing.
- A write that completes a load, and a gate rising edge, take effect at the clock edge that samples them. `out` and the count are therefore already updated at the falling edge that follows.
- The count and `out` change at the same edge as each sampled `tick`, so a run of n ticks is checked one half-cycle after its n-th edge.
- `rdata` is combinational from the count or the snapshot, and the read pointer moves at the edge of `rd_en`.

The bench drives every input and samples every output on falling edges, reading each byte just before it pulses `rd_en`.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

   typedef enum logic [2:0] {
      M_TERM_FLAG = 3'd0,
      M_ONE_SHOT  = 3'd1,
      M_RATE      = 3'd2,
      M_SQUARE    = 3'd3,
      M_SW_STROBE = 3'd4,
      M_HW_STROBE = 3'd5
   } mode_e;

   typedef enum logic [1:0] {
      ACC_LATCH = 2'b00,
      ACC_LO    = 2'b01,
      ACC_HI    = 2'b10,
      ACC_WORD  = 2'b11
   } acc_e;

   typedef struct packed {
      mode_e mode;
      acc_e  acc;
      logic  bcd;
   } cfg_t;

endpackage

// File: rtl/ivt_access.sv
module ivt_access
   import ivt_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                rd_en,
   input  logic                sel_ctrl,
   input  logic [BYTE_W-1:0]   wdata,
   input  logic [2*BYTE_W-1:0] cnt,
   output cfg_t                cfg,
   output mode_e               new_mode,
   output logic                ctrl_wr,
   output logic                load_wr,
   output logic [2*BYTE_W-1:0] wr_value,
   output logic [2*BYTE_W-1:0] init,
   output logic [BYTE_W-1:0]   rdata
);
   localparam int CNT_W = 2 * BYTE_W;

   logic              wr_hi;
   logic              rd_hi;
   logic              latched;
   logic [CNT_W-1:0]  hold;
   logic [BYTE_W-1:0] lo_byte;
   logic              is_ctrl;
   logic              is_latch;
   cfg_t              cfg_in;
   logic [CNT_W-1:0]  rd_src;
   logic              rd_high_sel;

   // decode of an incoming control byte; mode codes 6/7 alias 2/3
   always_comb begin
      logic [2:0] m;
      m = wdata[3:1];
      if (m[1]) m[2] = 1'b0;
      cfg_in.mode = mode_e'(m);
      cfg_in.acc  = acc_e'(wdata[5:4]);
      cfg_in.bcd  = wdata[0];
   end

   assign new_mode = cfg_in.mode;
   assign is_ctrl  = wr_en & sel_ctrl;
   assign is_latch = is_ctrl & (cfg_in.acc == ACC_LATCH);
   assign ctrl_wr  = is_ctrl & ~is_latch;
   assign load_wr  = wr_en & ~sel_ctrl & ((cfg.acc != ACC_WORD) | wr_hi);

   always_comb begin
      case (cfg.acc)
         ACC_HI:   wr_value = {wdata, {BYTE_W{1'b0}}};
         ACC_WORD: wr_value = {wdata, lo_byte};
         default:  wr_value = {{BYTE_W{1'b0}}, wdata};
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg     <= '{mode: M_TERM_FLAG, acc: ACC_LO, bcd: 1'b0};
         wr_hi   <= 1'b0;
         rd_hi   <= 1'b0;
         latched <= 1'b0;
         hold    <= '0;
         lo_byte <= '0;
         init    <= '0;
      end else begin
         if (is_latch) begin
            if (!latched) begin
               latched <= 1'b1;
               hold    <= cnt;
            end
         end else if (ctrl_wr) begin
            cfg     <= cfg_in;
            wr_hi   <= 1'b0;
            rd_hi   <= 1'b0;
            latched <= 1'b0;
         end else if (wr_en) begin
            if (load_wr) begin
               init  <= wr_value;
               wr_hi <= 1'b0;
            end else begin
               lo_byte <= wdata;
               wr_hi   <= 1'b1;
            end
         end
         if (rd_en) begin
            if (cfg.acc == ACC_WORD) rd_hi <= ~rd_hi;
            if (cfg.acc != ACC_WORD || rd_hi) latched <= 1'b0;
         end
      end
   end

   assign rd_src      = latched ? hold : cnt;
   assign rd_high_sel = (cfg.acc == ACC_HI) | ((cfg.acc == ACC_WORD) & rd_hi);
   assign rdata       = rd_high_sel ? rd_src[CNT_W-1:BYTE_W] : rd_src[BYTE_W-1:0];

   // R12: a frozen snapshot never changes while it stays held
   a_r12_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (latched && $past(latched)) |-> (hold == $past(hold)));

endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
   parameter int BYTE_W  = 8,
   parameter bit HAS_BCD = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [2*BYTE_W-1:0] load_val,
   input  logic                dec,
   input  logic                bcd,
   output logic [2*BYTE_W-1:0] cnt
);
   localparam int CNT_W = 2 * BYTE_W;
   localparam int DIGITS = CNT_W / 4;
   localparam logic [CNT_W-1:0] BCD_MAX = {DIGITS{4'h9}};

   logic [CNT_W-1:0] nxt;

   function automatic logic [CNT_W-1:0] bcd_dec(input logic [CNT_W-1:0] v);
      logic [CNT_W-1:0] r;
      logic             borrow;
      r      = v;
      borrow = 1'b1;
      for (int i = 0; i < DIGITS; i++) begin
         if (borrow) begin
            if (v[4*i +: 4] == 4'd0) begin
               r[4*i +: 4] = 4'd9;
            end else begin
               r[4*i +: 4] = v[4*i +: 4] - 4'd1;
               borrow      = 1'b0;
            end
         end
      end
      return r;
   endfunction

   generate
      if (HAS_BCD) begin : g_bcd
         assign nxt = bcd ? bcd_dec(cnt) : cnt - CNT_W'(1);

         // R4: decimal count wraps from all zeros to all nines
         a_r4_bcd_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            (bcd && dec && !load && cnt == '0) |=> (cnt == BCD_MAX));
      end else begin : g_bin
         logic unused_bcd;
         assign unused_bcd = bcd;
         assign nxt = cnt - CNT_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (load) cnt <= load_val;
      else if (dec)  cnt <= nxt;
   end

endmodule

// File: rtl/ivt_wave.sv
module ivt_wave
   import ivt_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter bit HAS_BCD = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  cfg_t                cfg,
   input  mode_e               new_mode,
   input  logic                ctrl_wr,
   input  logic                load_wr,
   input  logic [2*BYTE_W-1:0] wr_value,
   input  logic [2*BYTE_W-1:0] init,
   input  logic                gate,
   input  logic                tick,
   input  logic [2*BYTE_W-1:0] cnt,
   output logic                cnt_load,
   output logic [2*BYTE_W-1:0] cnt_load_val,
   output logic                cnt_dec,
   output logic                out
);
   localparam int CNT_W = 2 * BYTE_W;
   localparam int DIGITS = CNT_W / 4;
   localparam int PER_W = CNT_W + 1;

   function automatic logic [PER_W-1:0] pow10(input int n);
      logic [PER_W-1:0] p;
      p = PER_W'(1);
      for (int i = 0; i < n; i++) p = (p << 3) + (p << 1);
      return p;
   endfunction

   localparam logic [PER_W-1:0] BCD_ZERO_PER = pow10(DIGITS);
   localparam logic [PER_W-1:0] BIN_ZERO_PER = PER_W'(1) << CNT_W;

   function automatic logic [PER_W-1:0] bcd_to_bin(input logic [CNT_W-1:0] v);
      logic [PER_W-1:0] acc;
      acc = '0;
      for (int i = DIGITS - 1; i >= 0; i--)
         acc = (acc << 3) + (acc << 1) + PER_W'(v[4*i +: 4]);
      return acc;
   endfunction

   logic             gate_q;
   logic             armed;
   logic             running;
   logic             fired;
   logic             out_q;
   logic [PER_W-1:0] phase;
   logic             use_bcd;
   logic             gated_mode;
   logic             edge_mode;
   logic             trig;
   logic             term;
   logic             cnt_en;
   logic             reload;
   logic [PER_W-1:0] period;
   logic [PER_W-1:0] half;

   assign use_bcd    = HAS_BCD && cfg.bcd;
   assign gated_mode = (cfg.mode == M_TERM_FLAG) || (cfg.mode == M_RATE) ||
                       (cfg.mode == M_SQUARE)    || (cfg.mode == M_SW_STROBE);
   assign edge_mode  = (cfg.mode != M_TERM_FLAG) && (cfg.mode != M_SW_STROBE);
   assign trig       = armed & gate & ~gate_q & edge_mode & ~ctrl_wr & ~load_wr;
   assign term       = (cnt == CNT_W'(1));
   assign cnt_en     = tick & (gated_mode ? (armed & gate) : running);
   assign reload     = trig | (cnt_en & term & ~load_wr & ~ctrl_wr &
                               ((cfg.mode == M_RATE) || (cfg.mode == M_SQUARE)));

   assign cnt_load     = (load_wr & gated_mode) | reload;
   assign cnt_load_val = load_wr ? wr_value : init;
   assign cnt_dec      = cnt_en & ~load_wr & ~ctrl_wr & ~reload;

   always_comb begin
      if (init == '0)  period = use_bcd ? BCD_ZERO_PER : BIN_ZERO_PER;
      else if (use_bcd) period = bcd_to_bin(init);
      else              period = {1'b0, init};
      half = (period + PER_W'(1)) >> 1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gate_q  <= 1'b0;
         armed   <= 1'b0;
         running <= 1'b0;
         fired   <= 1'b0;
         out_q   <= 1'b1;
         phase   <= '0;
      end else begin
         gate_q <= gate;
         if (ctrl_wr) begin
            armed   <= 1'b0;
            running <= 1'b0;
            fired   <= 1'b0;
            phase   <= '0;
            out_q   <= (new_mode != M_TERM_FLAG);
         end else if (load_wr) begin
            armed <= 1'b1;
            fired <= 1'b0;
            phase <= '0;
            out_q <= (cfg.mode != M_TERM_FLAG);
         end else if (trig) begin
            running <= 1'b1;
            fired   <= 1'b0;
            phase   <= '0;
            out_q   <= (cfg.mode != M_ONE_SHOT);
         end else if (cnt_en) begin
            phase <= reload ? '0 : phase + PER_W'(1);
            case (cfg.mode)
               M_TERM_FLAG, M_ONE_SHOT: if (term) out_q <= 1'b1;
               M_RATE:                  out_q <= ~term;
               M_SW_STROBE, M_HW_STROBE: begin
                  if (term && !fired) begin
                     out_q <= 1'b0;
                     fired <= 1'b1;
                  end else begin
                     out_q <= 1'b1;
                  end
               end
               default: out_q <= 1'b1;
            endcase
         end
      end
   end

   assign out = (cfg.mode == M_SQUARE) ? (phase < half) : out_q;

   // R5: the terminal flag rises only when the count has reached zero
   a_r5_flag_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.mode == M_TERM_FLAG && $rose(out_q)) |-> (cnt == '0));

   // R6: the one-shot output is low only while a triggered run is active
   a_r6_low_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.mode == M_ONE_SHOT && !out_q) |-> running);

   // R7: each rate pulse begins exactly when the count is reloaded
   a_r7_pulse_on_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.mode == M_RATE && $fell(out_q)) |-> (cnt == init));

   // R11: a low gate holds the count in level-gated modes
   a_r11_gate_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (gated_mode && !gate && !cnt_load) |=> $stable(cnt));

endmodule

// File: rtl/pit_channel.sv
module pit_channel
   import ivt_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter bit HAS_BCD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              gate,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              sel_ctrl,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata,
   output logic              out
);
   localparam int CNT_W = 2 * BYTE_W;

   generate
      if (BYTE_W < 6 || (BYTE_W % 2) != 0) begin : g_bad_width
         $error("pit_channel: BYTE_W must be even and at least 6");
      end
   endgenerate

   cfg_t             cfg;
   mode_e            new_mode;
   logic             ctrl_wr;
   logic             load_wr;
   logic [CNT_W-1:0] wr_value;
   logic [CNT_W-1:0] init;
   logic [CNT_W-1:0] cnt;
   logic             cnt_load;
   logic [CNT_W-1:0] cnt_load_val;
   logic             cnt_dec;

   ivt_access #(.BYTE_W(BYTE_W)) u_access (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .rd_en    (rd_en),
      .sel_ctrl (sel_ctrl),
      .wdata    (wdata),
      .cnt      (cnt),
      .cfg      (cfg),
      .new_mode (new_mode),
      .ctrl_wr  (ctrl_wr),
      .load_wr  (load_wr),
      .wr_value (wr_value),
      .init     (init),
      .rdata    (rdata)
   );

   ivt_wave #(.BYTE_W(BYTE_W), .HAS_BCD(HAS_BCD)) u_wave (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg          (cfg),
      .new_mode     (new_mode),
      .ctrl_wr      (ctrl_wr),
      .load_wr      (load_wr),
      .wr_value     (wr_value),
      .init         (init),
      .gate         (gate),
      .tick         (tick),
      .cnt          (cnt),
      .cnt_load     (cnt_load),
      .cnt_load_val (cnt_load_val),
      .cnt_dec      (cnt_dec),
      .out          (out)
   );

   ivt_counter #(.BYTE_W(BYTE_W), .HAS_BCD(HAS_BCD)) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (cnt_load_val),
      .dec      (cnt_dec),
      .bcd      (cfg.bcd),
      .cnt      (cnt)
   );

endmodule

// File: tb/test_pit_channel.sv
module test_pit_channel;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       tick;
   logic       gate;
   logic       wr_en;
   logic       rd_en;
   logic       sel_ctrl;
   logic [7:0] wdata;
   logic [7:0] rdata;
   logic       out;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   pit_channel i_pit_channel (
      .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .wr_en(wr_en),
      .rd_en(rd_en), .sel_ctrl(sel_ctrl), .wdata(wdata), .rdata(rdata), .out(out)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic ctrl, input logic [7:0] b);
      @(negedge clk);
      wr_en = 1'b1; sel_ctrl = ctrl; wdata = b;
      @(negedge clk);
      wr_en = 1'b0; sel_ctrl = 1'b0;
   endtask

   task automatic rd(output logic [7:0] v);
      @(negedge clk);
      v = rdata; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic run(input int n);
      if (n > 0) begin
         @(negedge clk);
         tick = 1'b1;
         repeat (n) @(negedge clk);
         tick = 1'b0;
      end
   endtask

   task automatic set_gate(input logic v);
      @(negedge clk);
      gate = v;
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 reset out", out, 1);
      chk("R1 reset count", rdata, 0);
   endtask

   task automatic t_mode0();
      logic [7:0] v;
      wr(1, 8'h30); wr(0, 8'h05); wr(0, 8'h00);
      chk("R5 low after load", out, 0);
      run(4); chk("R5 low before terminal", out, 0);
      run(1); chk("R5 high at terminal", out, 1);
      run(3); chk("R5 stays high", out, 1);
      rd(v); chk("R4 binary wrap low", v, 8'hFD);
      rd(v); chk("R2 word read high", v, 8'hFF);
      wr(1, 8'h30); chk("R5 control write drops out", out, 0);
   endtask

   task automatic t_gate_m0();
      logic [7:0] v;
      wr(1, 8'h10); wr(0, 8'h03);
      set_gate(0); run(5);
      rd(v); chk("R11 gate low holds", v, 8'h03);
      chk("R5 still low", out, 0);
      set_gate(1);
      rd(v); chk("R11 no reload mode0", v, 8'h03);
      run(3); chk("R5 terminal after gate", out, 1);
   endtask

   task automatic t_msb();
      logic [7:0] v;
      wr(1, 8'h20); wr(0, 8'h02);
      rd(v); chk("R2 high-only load", v, 8'h02);
      run(1);
      rd(v); chk("R2 high-only read", v, 8'h01);
   endtask

   task automatic t_latch();
      logic [7:0] v;
      wr(1, 8'h30); wr(0, 8'h34); wr(0, 8'h12);
      run(4); wr(1, 8'h00);
      run(5); wr(1, 8'h00);
      run(1);
      rd(v); chk("R12 held low", v, 8'h30);
      rd(v); chk("R12 held high", v, 8'h12);
      rd(v); chk("R12 live low", v, 8'h2A);
      rd(v); chk("R12 live high", v, 8'h12);
   endtask

   task automatic t_mode2();
      logic [7:0] v;
      wr(1, 8'h14); wr(0, 8'h03);
      chk("R7 no pulse at load", out, 1);
      for (int k = 1; k <= 7; k++) begin
         run(1); chk("R7 rate pulse", out, (k % 3 == 0) ? 0 : 1);
      end
      rd(v); chk("R7 reloaded count", v, 8'h02);
      set_gate(0); run(2);
      rd(v); chk("R11 gate low holds mode2", v, 8'h02);
      set_gate(1);
      rd(v); chk("R11 rising gate reloads mode2", v, 8'h03);
   endtask

   task automatic t_mode3();
      wr(1, 8'h16); wr(0, 8'h05);
      chk("R8 high after load", out, 1);
      for (int k = 1; k <= 10; k++) begin
         run(1); chk("R8 odd square", out, ((k % 5) < 3) ? 1 : 0);
      end
      wr(0, 8'h04);
      for (int k = 1; k <= 8; k++) begin
         run(1); chk("R8 even square", out, ((k % 4) < 2) ? 1 : 0);
      end
   endtask

   task automatic t_bcd();
      logic [7:0] v;
      wr(1, 8'h31); wr(0, 8'h02); wr(0, 8'h00);
      run(3);
      rd(v); chk("R4 bcd wrap low", v, 8'h99);
      rd(v); chk("R4 bcd wrap high", v, 8'h99);
      wr(1, 8'h17); wr(0, 8'h10);
      for (int k = 1; k <= 12; k++) begin
         run(1); chk("R8 bcd square", out, ((k % 10) < 5) ? 1 : 0);
      end
      rd(v); chk("R4 bcd borrow", v, 8'h08);
   endtask

   task automatic t_mode4();
      logic [7:0] v;
      wr(1, 8'h18); wr(0, 8'h03);
      chk("R9 high after load", out, 1);
      run(2); chk("R9 before strobe", out, 1);
      run(1); chk("R9 strobe", out, 0);
      run(1); chk("R9 strobe ends", out, 1);
      run(3); chk("R9 no second strobe", out, 1);
      set_gate(0); set_gate(1);
      rd(v); chk("R11 no reload mode4", v, 8'hFC);
   endtask

   task automatic t_mode1();
      logic [7:0] v;
      set_gate(0);
      wr(1, 8'h12); wr(0, 8'h03);
      chk("R6 high before trigger", out, 1);
      run(2); chk("R6 untriggered", out, 1);
      set_gate(1); chk("R6 low on trigger", out, 0);
      run(2); chk("R6 still low", out, 0);
      run(1); chk("R6 high at terminal", out, 1);
      run(2); chk("R6 stays high", out, 1);
      set_gate(0); set_gate(1);
      chk("R6 retrigger", out, 0);
      rd(v); chk("R6 retrigger reload", v, 8'h03);
   endtask

   task automatic t_mode5();
      set_gate(0);
      wr(1, 8'h1A); wr(0, 8'h02);
      run(3); chk("R10 untriggered", out, 1);
      set_gate(1);
      run(1); chk("R10 before strobe", out, 1);
      run(1); chk("R10 strobe", out, 0);
      run(1); chk("R10 strobe ends", out, 1);
      run(2); chk("R10 single strobe", out, 1);
   endtask

   task automatic t_zero();
      logic [7:0] v;
      wr(1, 8'h15); wr(0, 8'h00);
      run(9999); chk("R3 no pulse before 10000", out, 1);
      run(1); chk("R3 pulse at 10000", out, 0);
      run(1); chk("R3 pulse ends", out, 1);
      rd(v); chk("R3 reload zero then count", v, 8'h99);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; tick = 1'b0; gate = 1'b1; wr_en = 1'b0;
      rd_en = 1'b0; sel_ctrl = 1'b0; wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mode0();
      t_gate_m0();
      t_msb();
      t_latch();
      t_mode2();
      t_mode3();
      t_bcd();
      t_mode4();
      t_mode1();
      t_mode5();
      set_gate(1);
      t_zero();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule